// File: doc/BRIEF.md
# USB PHY Power-Up and Shutdown Sequencer

This block holds the control registers that configure a USB 3.0 PHY and steps them through a fixed bring-up or shutdown sequence. The registers appear as flat output ports. A single-cycle init request starts bring-up for one of two ports, selected by a port-select input: the high-speed (UTMI) port or the SuperSpeed (PIPE3) port. A single-cycle exit request puts the PHY into a low-leakage, suspended state. The sequencer accepts a request only when it is idle. It signals the end of either sequence with a one-cycle done pulse.

Bring-up runs in a fixed order. It clears the configuration-port and resume registers, programs the link register with the frame-length adjust value, and switches the reference source away from the pad. It then applies tuning that depends on the selected port. Next it composes the clock/reset word, with port reset set alongside every clock enable. Port reset is held for a window of `CYC_PER_US*HOLD_US` clock cycles, and after that only the port-reset bit is removed. A 3-bit reference-frequency code, captured with the request, sets the frequency-dependent fields of the clock/reset word.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset, the registers hold these values: crCtrlOut=0x00000003, resumeOut=0x00000001, linkOut=0, param0Out=0x80000055, param1Out=0x00000311, utmiOut=0, clkRstOut=0, testOut=0x0000000C and clkSelOut=0. `done` and `busy` are low.
- R2: An init sequence writes zero to crCtrlOut and to resumeOut.
- R3: An init sequence writes linkOut = 0x08000040. This sets bit 27 and places the value 0x20 in field [6:1].
- R4: An init sequence clears param0Out bit 31 and sets clkSelOut bit 2. It leaves every other bit of both registers unchanged.
- R5: With portSel=0 (high-speed port), init does four things: it sets param0Out[30:26]=0x09, sets param1Out[4:0]=0x1C, writes utmiOut=0x00000040 (bit 6 only) and clears testOut bit 2. All other bits are kept.
- R6: With portSel=1 (SuperSpeed port), init sets param1Out[4:0]=0x1C and clears testOut bit 3. It leaves param0Out[30:26], utmiOut and testOut bit 2 unchanged.
- R7: A single write of the clock/reset word does all of the following:
  - It sets [3:2]=3.
  - It sets bits 0, 1, 4, 19 and 20.
  - For the high-speed port, it places the captured reference code in [7:5].
  - For the SuperSpeed port, it sets [17:11] and [30:23] according to the reference code: code 7 gives 0x32/0x00, code 5 gives 0x68/0x88, code 4 gives 0x7D/0x00 and code 3 gives 0x02/0x88. Any other code leaves both fields unchanged.
- R8: Port reset (clkRstOut bit 1) stays high for exactly `CYC_PER_US*HOLD_US` cycles. It is then cleared, and no other bit of the word changes.
- R9: An exit sequence does three things: it writes utmiOut=0x00000043, clears clkRstOut bits 0, 19 and 20, and sets testOut bits 3 and 2. All other bits are kept.
- R10: `done` is high for exactly one cycle, in the first cycle in which all register values of the finished sequence are visible. `busy` falls in that same cycle.
- R11: Requests are sampled only while idle. Requests that arrive while busy have no effect. If init and exit arrive together while idle, init is taken.
- R12: The clock/reset word is written only after the link, clock-source and tuning writes have all taken effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| initReq | input | 1 | Start the bring-up sequence |
| exitReq | input | 1 | Start the shutdown sequence |
| portSel | input | 1 | Port to bring up: 0 = high-speed, 1 = SuperSpeed |
| refCode | input | 3 | Reference-frequency code |
| done | output | 1 | One-cycle pulse when a sequence completes |
| busy | output | 1 | A sequence is in progress |
| crCtrlOut | output | 32 | Configuration-port control register |
| resumeOut | output | 32 | Resume register |
| linkOut | output | 32 | Link system register |
| param0Out | output | 32 | PHY parameter register 0 |
| param1Out | output | 32 | PHY parameter register 1 |
| utmiOut | output | 32 | High-speed power control register |
| clkRstOut | output | 32 | Clock/reset word |
| testOut | output | 32 | Power-down test register |
| clkSelOut | output | 32 | Clock-select register |

## Verification
Init is exercised for both ports across all eight reference codes, including codes that have no table entry. This separates a missing or wrong field update from a read-modify-write that damages bits it should keep. Init and exit runs are interleaved in random order, so each one starts from whatever state the previous sequence left. That exposes any write that is absolute where it should be a read-modify-write, or the reverse. While a sequence is running, random init and exit pulses are injected. Any request that is wrongly accepted then shows up in the utmi or test register. A simultaneous init and exit from idle checks the priority rule. The length of the port-reset window is counted on every run.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  localparam int REG_W = 32;
  localparam int REF_W = 3;

  // link register
  localparam int LNK_VER_BIT = 27;
  localparam int LNK_ADJ_LO  = 1;
  localparam int LNK_ADJ_W   = 6;
  localparam logic [LNK_ADJ_W-1:0] LNK_ADJ_VAL = 6'h20;

  // clock-source bits
  localparam int P0_PAD_BIT = 31;
  localparam int SEL_CLK_BIT = 2;

  // tuning fields
  localparam int P0_LOS_LO = 26;
  localparam int P0_LOS_W  = 5;
  localparam logic [P0_LOS_W-1:0] P0_LOS_VAL = 5'h09;
  localparam int P1_DEEM_LO = 0;
  localparam int P1_DEEM_W  = 5;
  localparam logic [P1_DEEM_W-1:0] P1_DEEM_VAL = 5'h1C;

  // high-speed power control bits
  localparam int HSC_OTGOFF_BIT = 6;
  localparam int HSC_SUSP_BIT   = 1;
  localparam int HSC_SLEEP_BIT  = 0;

  // test register power-down bits
  localparam int TST_SSPD_BIT = 3;
  localparam int TST_HSPD_BIT = 2;

  // clock/reset word
  localparam int CW_COMMON_BIT = 0;
  localparam int CW_PRST_BIT   = 1;
  localparam int CW_RSEL_LO    = 2;
  localparam int CW_RSEL_W     = 2;
  localparam logic [CW_RSEL_W-1:0] CW_RSEL_EXT = 2'b11;
  localparam int CW_RETEN_BIT  = 4;
  localparam int CW_FSEL_LO    = 5;
  localparam int CW_MULT_LO    = 11;
  localparam int CW_MULT_W     = 7;
  localparam int CW_SSREF_BIT  = 19;
  localparam int CW_SSC_BIT    = 20;
  localparam int CW_SSCSEL_LO  = 23;
  localparam int CW_SSCSEL_W   = 8;

  // reference codes with a SuperSpeed table entry
  localparam logic [REF_W-1:0] RC_19M2 = 3'd3;
  localparam logic [REF_W-1:0] RC_20M  = 3'd4;
  localparam logic [REF_W-1:0] RC_24M  = 3'd5;
  localparam logic [REF_W-1:0] RC_50M  = 3'd7;

  // reset contents
  localparam logic [REG_W-1:0] RST_CR     = 32'h0000_0003;
  localparam logic [REG_W-1:0] RST_RESUME = 32'h0000_0001;
  localparam logic [REG_W-1:0] RST_LINK   = 32'h0000_0000;
  localparam logic [REG_W-1:0] RST_P0     = 32'h8000_0055;
  localparam logic [REG_W-1:0] RST_P1     = 32'h0000_0311;
  localparam logic [REG_W-1:0] RST_HSC    = 32'h0000_0000;
  localparam logic [REG_W-1:0] RST_CW     = 32'h0000_0000;
  localparam logic [REG_W-1:0] RST_TEST   = 32'h0000_000C;
  localparam logic [REG_W-1:0] RST_SEL    = 32'h0000_0000;

  localparam logic [REG_W-1:0] LINK_VAL =
    (REG_W'(1) << LNK_VER_BIT) | (REG_W'(LNK_ADJ_VAL) << LNK_ADJ_LO);
  localparam logic [REG_W-1:0] HSC_RUN  = REG_W'(1) << HSC_OTGOFF_BIT;
  localparam logic [REG_W-1:0] HSC_EXIT = HSC_RUN | (REG_W'(1) << HSC_SUSP_BIT)
                                        | (REG_W'(1) << HSC_SLEEP_BIT);

  typedef struct packed {
    logic clrCr;
    logic progLink;
    logic selClk;
    logic tuneHs;
    logic tuneSs;
    logic loadWord;
    logic dropRst;
    logic exitHsc;
    logic exitClk;
    logic exitTest;
  } seqStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CLR, ST_LINK, ST_SRC, ST_TUNE, ST_WORD, ST_HOLD, ST_REL,
    ST_XHSC, ST_XCLK, ST_XTEST
  } seqState_t;
endpackage

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
#(
  parameter int HOLD_CYC = 2000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initReq,
  input  logic             exitReq,
  input  logic             portSel,
  input  logic [REF_W-1:0] refCode,
  output seqStrobe_t       strobe,
  output logic             portQ,
  output logic [REF_W-1:0] refQ,
  output logic             done,
  output logic             busy
);
  localparam int CNT_W = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYC - 2);

  seqState_t state, nextState;
  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      portQ   <= 1'b0;
      refQ    <= '0;
      holdCnt <= '0;
      done    <= 1'b0;
    end else begin
      state <= nextState;
      done  <= (state == ST_REL) || (state == ST_XTEST);
      if (state == ST_IDLE && initReq) begin
        portQ <= portSel;
        refQ  <= refCode;
      end
      if (state == ST_WORD) begin
        holdCnt <= HOLD_LOAD;
      end else if (state == ST_HOLD && holdCnt != '0) begin
        holdCnt <= holdCnt - 1'b1;
      end
    end
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (initReq)      nextState = ST_CLR;
        else if (exitReq) nextState = ST_XHSC;
      end
      ST_CLR:   nextState = ST_LINK;
      ST_LINK:  nextState = ST_SRC;
      ST_SRC:   nextState = ST_TUNE;
      ST_TUNE:  nextState = ST_WORD;
      ST_WORD:  nextState = ST_HOLD;
      ST_HOLD:  if (holdCnt == '0) nextState = ST_REL;
      ST_REL:   nextState = ST_IDLE;
      ST_XHSC:  nextState = ST_XCLK;
      ST_XCLK:  nextState = ST_XTEST;
      ST_XTEST: nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe          = '0;
    strobe.clrCr    = (state == ST_CLR);
    strobe.progLink = (state == ST_LINK);
    strobe.selClk   = (state == ST_SRC);
    strobe.tuneHs   = (state == ST_TUNE) && !portQ;
    strobe.tuneSs   = (state == ST_TUNE) && portQ;
    strobe.loadWord = (state == ST_WORD);
    strobe.dropRst  = (state == ST_REL);
    strobe.exitHsc  = (state == ST_XHSC);
    strobe.exitClk  = (state == ST_XCLK);
    strobe.exitTest = (state == ST_XTEST);
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/phy_seq_clkword.sv
module phy_seq_clkword
  import phy_seq_pkg::*;
(
  input  logic [REG_W-1:0] curWord,
  input  logic             portQ,
  input  logic [REF_W-1:0] refQ,
  output logic [REG_W-1:0] newWord
);
  always_comb begin
    newWord = curWord;
    newWord[CW_RSEL_LO +: CW_RSEL_W] = CW_RSEL_EXT;
    if (!portQ) begin
      newWord[CW_FSEL_LO +: REF_W] = refQ;
    end else begin
      case (refQ)
        RC_50M: begin
          newWord[CW_MULT_LO +: CW_MULT_W]     = 7'h32;
          newWord[CW_SSCSEL_LO +: CW_SSCSEL_W] = 8'h00;
        end
        RC_24M: begin
          newWord[CW_MULT_LO +: CW_MULT_W]     = 7'h68;
          newWord[CW_SSCSEL_LO +: CW_SSCSEL_W] = 8'h88;
        end
        RC_20M: begin
          newWord[CW_MULT_LO +: CW_MULT_W]     = 7'h7D;
          newWord[CW_SSCSEL_LO +: CW_SSCSEL_W] = 8'h00;
        end
        RC_19M2: begin
          newWord[CW_MULT_LO +: CW_MULT_W]     = 7'h02;
          newWord[CW_SSCSEL_LO +: CW_SSCSEL_W] = 8'h88;
        end
        default: ;
      endcase
    end
    newWord[CW_RETEN_BIT]  = 1'b1;
    newWord[CW_SSREF_BIT]  = 1'b1;
    newWord[CW_SSC_BIT]    = 1'b1;
    newWord[CW_COMMON_BIT] = 1'b1;
    newWord[CW_PRST_BIT]   = 1'b1;
  end
endmodule

// File: rtl/phy_seq_regs.sv
module phy_seq_regs
  import phy_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             portQ,
  input  logic [REF_W-1:0] refQ,
  output logic [REG_W-1:0] crQ,
  output logic [REG_W-1:0] resumeQ,
  output logic [REG_W-1:0] linkQ,
  output logic [REG_W-1:0] param0Q,
  output logic [REG_W-1:0] param1Q,
  output logic [REG_W-1:0] hscQ,
  output logic [REG_W-1:0] clkRstQ,
  output logic [REG_W-1:0] testQ,
  output logic [REG_W-1:0] clkSelQ
);
  logic [REG_W-1:0] wordNext;

  phy_seq_clkword uWord (
    .curWord(clkRstQ),
    .portQ  (portQ),
    .refQ   (refQ),
    .newWord(wordNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crQ     <= RST_CR;
      resumeQ <= RST_RESUME;
      linkQ   <= RST_LINK;
      param0Q <= RST_P0;
      param1Q <= RST_P1;
      hscQ    <= RST_HSC;
      clkRstQ <= RST_CW;
      testQ   <= RST_TEST;
      clkSelQ <= RST_SEL;
    end else begin
      if (strobe.clrCr) begin
        crQ     <= '0;
        resumeQ <= '0;
      end
      if (strobe.progLink) linkQ <= LINK_VAL;
      if (strobe.selClk) begin
        param0Q[P0_PAD_BIT]  <= 1'b0;
        clkSelQ[SEL_CLK_BIT] <= 1'b1;
      end
      if (strobe.tuneHs) begin
        param0Q[P0_LOS_LO +: P0_LOS_W]   <= P0_LOS_VAL;
        param1Q[P1_DEEM_LO +: P1_DEEM_W] <= P1_DEEM_VAL;
        hscQ                             <= HSC_RUN;
        testQ[TST_HSPD_BIT]              <= 1'b0;
      end
      if (strobe.tuneSs) begin
        param1Q[P1_DEEM_LO +: P1_DEEM_W] <= P1_DEEM_VAL;
        testQ[TST_SSPD_BIT]              <= 1'b0;
      end
      if (strobe.loadWord) clkRstQ <= wordNext;
      if (strobe.dropRst)  clkRstQ[CW_PRST_BIT] <= 1'b0;
      if (strobe.exitHsc)  hscQ <= HSC_EXIT;
      if (strobe.exitClk) begin
        clkRstQ[CW_SSREF_BIT]  <= 1'b0;
        clkRstQ[CW_SSC_BIT]    <= 1'b0;
        clkRstQ[CW_COMMON_BIT] <= 1'b0;
      end
      if (strobe.exitTest) begin
        testQ[TST_SSPD_BIT] <= 1'b1;
        testQ[TST_HSPD_BIT] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_seq_pkg::*;
#(
  parameter int CYC_PER_US = 200,
  parameter int HOLD_US    = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initReq,
  input  logic             exitReq,
  input  logic             portSel,
  input  logic [REF_W-1:0] refCode,
  output logic             done,
  output logic             busy,
  output logic [REG_W-1:0] crCtrlOut,
  output logic [REG_W-1:0] resumeOut,
  output logic [REG_W-1:0] linkOut,
  output logic [REG_W-1:0] param0Out,
  output logic [REG_W-1:0] param1Out,
  output logic [REG_W-1:0] utmiOut,
  output logic [REG_W-1:0] clkRstOut,
  output logic [REG_W-1:0] testOut,
  output logic [REG_W-1:0] clkSelOut
);
  localparam int HOLD_CYC = CYC_PER_US * HOLD_US;

  seqStrobe_t       strobe;
  logic             portQ;
  logic [REF_W-1:0] refQ;

  phy_seq_ctrl #(.HOLD_CYC(HOLD_CYC)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .initReq(initReq),
    .exitReq(exitReq),
    .portSel(portSel),
    .refCode(refCode),
    .strobe (strobe),
    .portQ  (portQ),
    .refQ   (refQ),
    .done   (done),
    .busy   (busy)
  );

  phy_seq_regs uRegs (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .portQ  (portQ),
    .refQ   (refQ),
    .crQ    (crCtrlOut),
    .resumeQ(resumeOut),
    .linkQ  (linkOut),
    .param0Q(param0Out),
    .param1Q(param1Out),
    .hscQ   (utmiOut),
    .clkRstQ(clkRstOut),
    .testQ  (testOut),
    .clkSelQ(clkSelOut)
  );
endmodule

// File: rtl/phy_pwr_seq_chk.sv
module phy_pwr_seq_chk
  import phy_seq_pkg::*;
#(
  parameter int HOLD_CYC = 2000
) (
  input logic             clk,
  input logic             rstN,
  input logic             done,
  input logic             busy,
  input logic [REG_W-1:0] linkOut,
  input logic [REG_W-1:0] param0Out,
  input logic [REG_W-1:0] utmiOut,
  input logic [REG_W-1:0] clkRstOut,
  input logic [REG_W-1:0] testOut,
  input logic [REG_W-1:0] clkSelOut
);
  localparam logic [REG_W-1:0] PR_MASK = REG_W'(1) << CW_PRST_BIT;
  localparam logic [REG_W-1:0] ON_MASK = PR_MASK | (REG_W'(1) << CW_COMMON_BIT)
    | (REG_W'(1) << CW_RETEN_BIT) | (REG_W'(1) << CW_SSREF_BIT)
    | (REG_W'(1) << CW_SSC_BIT) | (REG_W'(3) << CW_RSEL_LO);
  localparam logic [REG_W-1:0] OFF_MASK = (REG_W'(1) << CW_COMMON_BIT)
    | (REG_W'(1) << CW_SSREF_BIT) | (REG_W'(1) << CW_SSC_BIT);
  localparam logic [REG_W-1:0] PD_MASK = (REG_W'(1) << TST_SSPD_BIT)
    | (REG_W'(1) << TST_HSPD_BIT);
  localparam logic [REG_W-1:0] PAD_MASK = REG_W'(1) << P0_PAD_BIT;
  localparam logic [REG_W-1:0] CS_MASK  = REG_W'(1) << SEL_CLK_BIT;

  logic [31:0] hiCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hiCnt <= '0;
    else if ((clkRstOut & PR_MASK) != '0) hiCnt <= hiCnt + 1'b1;
    else hiCnt <= '0;
  end

  assert_word_onewrite_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkRstOut[CW_PRST_BIT]) |-> (clkRstOut & ON_MASK) == ON_MASK);

  assert_hold_window_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkRstOut[CW_PRST_BIT]) |-> hiCnt == 32'(HOLD_CYC));

  assert_release_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkRstOut[CW_PRST_BIT]) |-> clkRstOut == ($past(clkRstOut) & ~PR_MASK));

  assert_exit_lowleak_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && (testOut & PD_MASK) == PD_MASK) |->
      (utmiOut == HSC_EXIT && (clkRstOut & OFF_MASK) == '0));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_ends_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_write_order_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkRstOut[CW_PRST_BIT]) |->
      (linkOut == LINK_VAL && (clkSelOut & CS_MASK) != '0 && (param0Out & PAD_MASK) == '0));
endmodule

bind phy_pwr_seq phy_pwr_seq_chk #(.HOLD_CYC(CYC_PER_US * HOLD_US)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .done     (done),
  .busy     (busy),
  .linkOut  (linkOut),
  .param0Out(param0Out),
  .utmiOut  (utmiOut),
  .clkRstOut(clkRstOut),
  .testOut  (testOut),
  .clkSelOut(clkSelOut)
);

// File: tb/sim_phy_pwr_seq.sv
`timescale 1ns/1ps
module sim_phy_pwr_seq;
  localparam int CPU  = 200;
  localparam int HUS  = 10;
  localparam int HOLD = CPU * HUS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initReq = 1'b0, exitReq = 1'b0, portSel = 1'b0;
  logic [2:0] refCode = '0;
  logic done, busy;
  logic [31:0] crCtrlOut, resumeOut, linkOut, param0Out, param1Out;
  logic [31:0] utmiOut, clkRstOut, testOut, clkSelOut;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  logic [31:0] mCr, mRes, mLink, mP0, mP1, mHsc, mClk, mTest, mSel;

  always #2.5 clk = ~clk;

  phy_pwr_seq #(.CYC_PER_US(CPU), .HOLD_US(HUS)) u0 (
    .clk(clk), .rstN(rstN), .initReq(initReq), .exitReq(exitReq),
    .portSel(portSel), .refCode(refCode), .done(done), .busy(busy),
    .crCtrlOut(crCtrlOut), .resumeOut(resumeOut), .linkOut(linkOut),
    .param0Out(param0Out), .param1Out(param1Out), .utmiOut(utmiOut),
    .clkRstOut(clkRstOut), .testOut(testOut), .clkSelOut(clkSelOut)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input logic [31:0] cur,
                                          input logic port, input logic [2:0] code);
    logic [31:0] w = cur;
    w[3:2] = 2'b11;
    if (!port) w[7:5] = code;
    else begin
      case (code)
        3'd7: begin w[17:11] = 7'h32; w[30:23] = 8'h00; end
        3'd5: begin w[17:11] = 7'h68; w[30:23] = 8'h88; end
        3'd4: begin w[17:11] = 7'h7D; w[30:23] = 8'h00; end
        3'd3: begin w[17:11] = 7'h02; w[30:23] = 8'h88; end
        default: ;
      endcase
    end
    w = w | 32'h0018_0013;
    return w;
  endfunction

  task automatic modelInit(input logic port, input logic [2:0] code);
    mCr = 0; mRes = 0;
    mLink = 32'h0800_0040;
    mP0[31] = 1'b0; mSel[2] = 1'b1;
    mP1[4:0] = 5'h1C;
    if (!port) begin
      mP0[30:26] = 5'h09; mHsc = 32'h40; mTest[2] = 1'b0;
    end else begin
      mTest[3] = 1'b0;
    end
    mClk = expWord(mClk, port, code) & ~32'h2;
  endtask

  task automatic modelExit();
    mHsc = 32'h43;
    mClk = mClk & ~32'h0018_0001;
    mTest = mTest | 32'hC;
  endtask

  task automatic compareAll(input string req);
    chk({req, "/R2"}, "crCtrl", crCtrlOut, mCr);
    chk({req, "/R2"}, "resume", resumeOut, mRes);
    chk({req, "/R3"}, "link", linkOut, mLink);
    chk({req, "/R4"}, "clkSel", clkSelOut, mSel);
    chk({req, "/R5"}, "param0", param0Out, mP0);
    chk({req, "/R6"}, "param1", param1Out, mP1);
    chk({req, "/R9"}, "utmi", utmiOut, mHsc);
    chk({req, "/R7"}, "clkRst", clkRstOut, mClk);
    chk({req, "/R9"}, "test", testOut, mTest);
  endtask

  // isInit: start init; both: drive exit too (init must win, R11)
  task automatic runOp(input bit isInit, input logic port, input logic [2:0] code,
                       input bit both, input bit noise);
    int hiCyc = 0;
    bit seenHi = 0;
    bit got = 0;
    @(negedge clk);
    initReq = isInit; exitReq = !isInit || both;
    portSel = port; refCode = code;
    @(negedge clk);
    initReq = 0; exitReq = 0;
    if (isInit) modelInit(port, code); else modelExit();
    for (int i = 0; i < HOLD + 100 && !got; i++) begin
      if (clkRstOut[1]) begin
        if (!seenHi) begin
          seenHi = 1;
          chk("R12", "link before word", linkOut, 32'h0800_0040);
          chk("R12", "clksel before word", {31'b0, clkSelOut[2]}, 32'h1);
        end
        hiCyc++;
      end
      if (done) begin
        got = 1;
        chk("R10", "busy at done", {31'b0, busy}, 32'h0);
        compareAll(isInit ? "init" : "exit");
        if (isInit) chk("R8", "port reset cycles", hiCyc, HOLD);
        initReq = 0; exitReq = 0;
      end else begin
        initReq = noise && busy && ($urandom % 4 == 0);
        exitReq = noise && busy && ($urandom % 4 == 0);
        portSel = $urandom % 2; refCode = $urandom % 8;
        @(negedge clk);
      end
    end
    initReq = 0; exitReq = 0;
    chk("R10", "done seen", {31'b0, got}, 32'h1);
    @(negedge clk);
    chk("R10", "done one cycle", {31'b0, done}, 32'h0);
    compareAll("after R11");
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    mCr = 32'h3; mRes = 32'h1; mLink = 0; mP0 = 32'h8000_0055; mP1 = 32'h311;
    mHsc = 0; mClk = 0; mTest = 32'hC; mSel = 0;
    compareAll("R1 reset");
    chk("R1", "done", {31'b0, done}, 0);
    chk("R1", "busy", {31'b0, busy}, 0);
    // directed cases
    runOp(0, 0, 0, 0, 0);       // R9 exit from reset
    runOp(1, 0, 3'd5, 0, 1);    // R5 high-speed
    runOp(1, 1, 3'd7, 0, 1);    // R6 SuperSpeed 50
    runOp(1, 1, 3'd1, 0, 0);    // R7 unsupported code keeps fields
    runOp(0, 0, 0, 0, 1);       // R9
    runOp(1, 1, 3'd3, 1, 0);    // R11 init wins over exit
    runOp(1, 0, 3'd7, 0, 1);    // R5
    // random mix
    for (int k = 0; k < 10; k++) begin
      runOp($urandom % 3 != 0, $urandom % 2, $urandom % 8, $urandom % 4 == 0, 1);
    end
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChk++; nBad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule